// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the low-order word offset for a four-beat burst. When an access starts, the control logic raises a load strobe. The block then captures the two least significant bits of the requested address and uses them as the starting beat. Later beats come from a small binary beat counter. Each clock edge on which the active-low advance input is low steps the counter by one. Each edge on which it is high holds the counter, which suspends the burst.

A static order input selects one of two beat orders. With the input high, the order is interleaved and the offset is the start XOR the beat count. With the input low, the order is linear and the offset is the start plus the beat count, modulo four. After the fourth beat, one more advance brings the offset back to the start value.

The order input must not change while the block is in use. Integrators leave it tied high unless linear order is wanted. The offset and the beat index are combinational views of the two registers, so each one changes in the same clock edge that updates its register.

Top module: `burst_seq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the start value and the beat counter, so that after the edge `burstOffset` and `beatIdx` are both 0. Reset takes priority over load and advance.
- R2: A load (`loadStb` high, `rst` low) captures `addrLow` as the start value and sets `beatIdx` to 0. After that edge, `burstOffset` equals the captured `addrLow` in either order.
- R3: With `loadStb` low and `advanceN` low at an edge, `beatIdx` increases by one, modulo 4.
- R4: With `loadStb` low and `advanceN` high at an edge, `beatIdx` and `burstOffset` keep their values (burst suspended).
- R5: With `orderIlv` = 1 (interleaved), `burstOffset` = start XOR `beatIdx`. The four sequences are: from 00, 00,01,10,11; from 01, 01,00,11,10; from 10, 10,11,00,01; from 11, 11,10,01,00.
- R6: With `orderIlv` = 0 (linear), `burstOffset` = (start + `beatIdx`) mod 4. The four sequences are: from 00, 00,01,10,11; from 01, 01,10,11,00; from 10, 10,11,00,01; from 11, 11,00,01,10.
- R7: An advance after the fourth beat returns `beatIdx` to 0 and `burstOffset` to the start value.
- R8: A load in the same edge as an advance wins. The start value is replaced and `beatIdx` becomes 0, not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadStb | input | 1 | Load a new start value from `addrLow` |
| addrLow | input | BEAT_W | Low address bits that give the first beat |
| advanceN | input | 1 | Active-low advance; high suspends the burst |
| orderIlv | input | 1 | Static order select: 1 interleaved, 0 linear |
| burstOffset | output | BEAT_W | Current word offset within the burst |
| beatIdx | output | BEAT_W | Number of advances since the last load |

## Verification
The bench walks every start value through five advances in both orders. A design that swaps the XOR and the add, or that computes the linear order with a plain increment of the offset, shows a wrong beat on the 01 and 11 starts. The fifth advance catches a counter that sticks at the last beat or restarts at offset 0 instead of at the start. Suspended cycles in the middle of a burst expose a design that advances regardless of `advanceN`. A load asserted together with an advance exposes a design that gives the advance priority, because `beatIdx` then reads 1. A reset asserted together with a load checks that the offset reads 0 and not the new address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Strobes from the control decoder to the datapath; at most one is acted on per edge.
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } seqStrobe_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_ILV    = 1'b1
  } burstOrder_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       rst,
  input  logic       loadStb,
  input  logic       advanceN,
  output seqStrobe_t strb
);

  // Priority: reset, then load, then advance.
  always_comb begin
    strb.clear = rst;
    strb.load  = !rst && loadStb;
    strb.step  = !rst && !loadStb && !advanceN;
  end

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  seqStrobe_t        strb,
  input  logic [BEAT_W-1:0] loadVal,
  input  burstOrder_e       order,
  output logic [BEAT_W-1:0] offset,
  output logic [BEAT_W-1:0] count
);

  localparam logic [BEAT_W-1:0] ZERO = '0;
  localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);

  logic [BEAT_W-1:0] startQ;
  logic [BEAT_W-1:0] cntQ;
  logic [BEAT_W-1:0] linOff;
  logic [BEAT_W-1:0] ilvOff;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      startQ <= ZERO;
      cntQ   <= ZERO;
    end else if (strb.load) begin
      startQ <= loadVal;
      cntQ   <= ZERO;
    end else if (strb.step) begin
      cntQ   <= cntQ + ONE;
    end
  end

  // Interleaved order flips start bits bit by bit; linear adds with natural wrap.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilvOff[b] = startQ[b] ^ cntQ[b];
  end

  assign linOff = startQ + cntQ;

  always_comb begin
    unique case (order)
      ORDER_ILV:    offset = ilvOff;
      ORDER_LINEAR: offset = linOff;
      default:      offset = linOff;
    endcase
  end

  assign count = cntQ;

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadStb,
  input  logic [BEAT_W-1:0] addrLow,
  input  logic              advanceN,
  input  logic              orderIlv,
  output logic [BEAT_W-1:0] burstOffset,
  output logic [BEAT_W-1:0] beatIdx
);

  seqStrobe_t  strb;
  burstOrder_e order;

  assign order = burstOrder_e'(orderIlv);

  burst_seq_ctrl u_ctrl (
    .rst      (rst),
    .loadStb  (loadStb),
    .advanceN (advanceN),
    .strb     (strb)
  );

  burst_seq_dp #(.BEAT_W(BEAT_W)) u_dp (
    .clk     (clk),
    .strb    (strb),
    .loadVal (addrLow),
    .order   (order),
    .offset  (burstOffset),
    .count   (beatIdx)
  );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              loadStb,
  input logic [BEAT_W-1:0] addrLow,
  input logic              advanceN,
  input logic              orderIlv,
  input logic [BEAT_W-1:0] burstOffset,
  input logic [BEAT_W-1:0] beatIdx
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (beatIdx == '0) && (burstOffset == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> (beatIdx == '0) && (burstOffset == $past(addrLow)));

  // R3
  advance_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadStb && !advanceN) |=> beatIdx == BEAT_W'($past(beatIdx) + 1'b1));

  // R4
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadStb && advanceN) |=>
      $stable(beatIdx) && ($stable(orderIlv) ? $stable(burstOffset) : 1'b1));

  // R5
  ilv_start_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadStb && orderIlv) |=>
      (orderIlv ? ((burstOffset ^ beatIdx) == $past(burstOffset ^ beatIdx)) : 1'b1));

  // R6
  lin_start_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadStb && !orderIlv) |=>
      (!orderIlv ? (BEAT_W'(burstOffset - beatIdx) == BEAT_W'($past(burstOffset) - $past(beatIdx))) : 1'b1));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (loadStb && !advanceN) |=> beatIdx == '0);

endmodule

bind burst_seq_top burst_seq_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .loadStb     (loadStb),
  .addrLow     (addrLow),
  .advanceN    (advanceN),
  .orderIlv    (orderIlv),
  .burstOffset (burstOffset),
  .beatIdx     (beatIdx)
);

// File: tb/tb_burst_seq_top.sv
`timescale 1ns/1ps
module tb_burst_seq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadStb = 1'b0;
  logic [1:0] addrLow = 2'b00;
  logic       advanceN = 1'b1;
  logic       orderIlv = 1'b1;
  logic [1:0] burstOffset;
  logic [1:0] beatIdx;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  burst_seq_top #(.BEAT_W(2)) dut (
    .clk(clk), .rst(rst), .loadStb(loadStb), .addrLow(addrLow),
    .advanceN(advanceN), .orderIlv(orderIlv),
    .burstOffset(burstOffset), .beatIdx(beatIdx)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Offset computed from the requirements: XOR for interleaved, add for linear.
  function automatic logic [1:0] expOff(input logic ilv, input logic [1:0] s, input logic [1:0] k);
    return ilv ? (s ^ k) : 2'(s + k);
  endfunction

  // Apply inputs at the falling edge, sample 1 ns after the next rising edge.
  task automatic cyc(input logic r, input logic ld, input logic [1:0] a, input logic advN);
    @(negedge clk);
    rst = r; loadStb = ld; addrLow = a; advanceN = advN;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0; loadStb = 1'b0; advanceN = 1'b1;
  endtask

  task automatic t_reset();
    cyc(1'b1, 1'b0, 2'b00, 1'b1);
    chk("R1 offset", burstOffset, 2'b00);
    chk("R1 beat", beatIdx, 2'b00);
    // reset beats a simultaneous load
    cyc(1'b1, 1'b1, 2'b11, 1'b0);
    chk("R1 reset over load", burstOffset, 2'b00);
    chk("R1 reset over load beat", beatIdx, 2'b00);
  endtask

  task automatic t_walk(input logic ilv);
    orderIlv = ilv;
    for (int s = 0; s < 4; s++) begin
      cyc(1'b0, 1'b1, 2'(s), 1'b1);
      chk("R2 load offset", burstOffset, 2'(s));
      chk("R2 load beat", beatIdx, 2'b00);
      for (int k = 1; k <= 4; k++) begin
        cyc(1'b0, 1'b0, 2'b00, 1'b0);
        chk("R3 beat", beatIdx, 2'(k));
        chk(ilv ? "R5 ilv offset" : "R6 lin offset", burstOffset, expOff(ilv, 2'(s), 2'(k)));
      end
      chk("R7 wrap offset", burstOffset, 2'(s));
      chk("R7 wrap beat", beatIdx, 2'b00);
      cyc(1'b0, 1'b0, 2'b00, 1'b0);
      chk("R7 after wrap", burstOffset, expOff(ilv, 2'(s), 2'b01));
    end
  endtask

  task automatic t_suspend();
    orderIlv = 1'b0;
    cyc(1'b0, 1'b1, 2'b11, 1'b1);
    cyc(1'b0, 1'b0, 2'b00, 1'b0);
    chk("R6 lin 11 step", burstOffset, 2'b00);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b0, 2'b10, 1'b1);
      chk("R4 hold offset", burstOffset, 2'b00);
      chk("R4 hold beat", beatIdx, 2'b01);
    end
    cyc(1'b0, 1'b0, 2'b00, 1'b0);
    chk("R4 resume", burstOffset, 2'b01);
    chk("R4 resume beat", beatIdx, 2'b10);
  endtask

  task automatic t_load_wins();
    orderIlv = 1'b1;
    cyc(1'b0, 1'b1, 2'b01, 1'b0);
    cyc(1'b0, 1'b0, 2'b00, 1'b0);
    chk("R8 pre step", burstOffset, 2'b00);
    cyc(1'b0, 1'b1, 2'b10, 1'b0);
    chk("R8 load wins beat", beatIdx, 2'b00);
    chk("R8 load wins offset", burstOffset, 2'b10);
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_walk(1'b1);
    cyc(1'b1, 1'b0, 2'b00, 1'b1);
    t_walk(1'b0);
    t_suspend();
    t_load_wins();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule